// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

A synchronous memory with two fully independent access ports, A and B, on one shared clock. Each port can read or write any word in any cycle. When both ports are enabled on the same word in the same cycle, a fixed rule table decides the outcome instead of leaving it undefined. An active-low match output reports such a cycle as it happens.

A port that reads the word the other port is writing first gets the old contents. On the following cycle, if that port issues no new access, its read data switches to the winning writer's word. If both ports write the same word, port A's data is kept and port B's write is dropped.

Each port has its own optional output register, chosen by parameter, which adds one cycle of read latency. Another parameter per port picks whether that output register captures on the rising or the falling clock edge. The defaults give port A no output register and port B one output register, both on the rising edge.

Top module: `dpram_arb`

## Requirements
- R1: A cycle with a port's enable and write enable both high stores that port's write data at its address. Later reads from either port return that word.
- R2: A read is a cycle with enable high and write enable low. Its word appears on port A's read data after the next rising edge. On port B, with its output register, it appears one rising edge later.
- R3: match_no_o is low in exactly those cycles where both enables are high and both addresses are equal, whatever the write enables are. It is high in every other cycle.
- R4: When both ports read the same address in one cycle, both return the stored word.
- R5: When port A writes and port B reads the same address, port B first returns the old word. If port B is idle in the next cycle, its read data then changes to A's word, one stage later than its normal read result.
- R6: When port B writes and port A reads the same address, port A first returns the old word. If port A is idle in the next cycle, its read data then changes to B's word.
- R7: When both ports write the same address, only port A's word is stored.
- R8: A write enable with the port enable low stores nothing.
- R9: A port's read data holds its value through cycles in which that port does not read and has no pending update from a lost collision.
- R10: During and after reset both read outputs are zero. With both enables low, match_no_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_a_i | input | 1 | Port A access enable |
| we_a_i | input | 1 | Port A write enable |
| addr_a_i | input | 9 | Port A word address |
| wdata_a_i | input | 8 | Port A write data |
| rdata_a_o | output | 8 | Port A read data |
| en_b_i | input | 1 | Port B access enable |
| we_b_i | input | 1 | Port B write enable |
| addr_b_i | input | 9 | Port B word address |
| wdata_b_i | input | 8 | Port B write data |
| rdata_b_o | output | 8 | Port B read data |
| match_no_o | output | 1 | Low while both ports address the same word |

## Verification
A wrong stored word shows on the next read of that address: one cycle later on port A, two cycles later on port B. A lost update flag or a stale pending word shows one cycle after a collision, as read data that does not switch to the winner's word. A blocked write that slips through when both ports write corrupts the word, and the next read of that address shows it. Stimulus is kept to a small address window so that collisions of every kind happen often, and a bench-side model of memory contents, pending updates and output stages predicts every port value.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic [2:0] {
    COL_NONE  = 3'd0,
    COL_RR    = 3'd1,
    COL_AW_BR = 3'd2,
    COL_AR_BW = 3'd3,
    COL_WW    = 3'd4
  } col_e;
endpackage

// File: rtl/dpram_collide.sv
module dpram_collide
  import dpram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int AW     = 9
) (
  input  logic              en_a_i,
  input  logic              we_a_i,
  input  logic [AW-1:0]     addr_a_i,
  input  logic [DATA_W-1:0] wdata_a_i,
  input  logic              en_b_i,
  input  logic              we_b_i,
  input  logic [AW-1:0]     addr_b_i,
  input  logic [DATA_W-1:0] wdata_b_i,
  output col_e              kind_o,
  output logic              match_no_o,
  output logic              wr_a_o,
  output logic              wr_b_o,
  output logic              upd_a_o,
  output logic [DATA_W-1:0] upd_word_a_o,
  output logic              upd_b_o,
  output logic [DATA_W-1:0] upd_word_b_o
);
  logic same;

  assign same = en_a_i && en_b_i && (addr_a_i == addr_b_i);

  always_comb begin
    kind_o = COL_NONE;
    if (same) begin
      unique case ({we_a_i, we_b_i})
        2'b00:   kind_o = COL_RR;
        2'b10:   kind_o = COL_AW_BR;
        2'b01:   kind_o = COL_AR_BW;
        default: kind_o = COL_WW;
      endcase
    end
  end

  assign match_no_o   = ~same;
  assign wr_a_o       = en_a_i && we_a_i;
  // port B write is dropped when port A writes the same word
  assign wr_b_o       = en_b_i && we_b_i && (kind_o != COL_WW);
  // losing reader picks up the winner's word on the next cycle
  assign upd_a_o      = (kind_o == COL_AR_BW);
  assign upd_word_a_o = wdata_b_i;
  assign upd_b_o      = (kind_o == COL_AW_BR);
  assign upd_word_b_o = wdata_a_i;
endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_a_i,
  input  logic [AW-1:0]     addr_a_i,
  input  logic [DATA_W-1:0] wdata_a_i,
  input  logic              wr_b_i,
  input  logic [AW-1:0]     addr_b_i,
  input  logic [DATA_W-1:0] wdata_b_i,
  output logic [DATA_W-1:0] rdat_a_o,
  output logic [DATA_W-1:0] rdat_b_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_a_i) mem[addr_a_i] <= wdata_a_i;
    if (wr_b_i) mem[addr_b_i] <= wdata_b_i;
  end

  assign rdat_a_o = mem[addr_a_i];
  assign rdat_b_o = mem[addr_b_i];
endmodule

// File: rtl/dpram_rdport.sv
module dpram_rdport #(
  parameter int DATA_W  = 8,
  parameter bit OUT_REG = 1'b0,
  parameter bit CLK_INV = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] rd_word_i,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] upd_word_i,
  output logic              pend_o,
  output logic [DATA_W-1:0] data_o
);
  logic              pend_q;
  logic [DATA_W-1:0] pend_word_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_word_q <= '0;
      data_q      <= '0;
    end else begin
      pend_q <= upd_i;
      if (upd_i) pend_word_q <= upd_word_i;
      // a fresh read outranks a pending refresh
      if (rd_en_i)     data_q <= rd_word_i;
      else if (pend_q) data_q <= pend_word_q;
    end
  end

  assign pend_o = pend_q;

  if (OUT_REG) begin : g_oreg
    logic              oclk;
    logic [DATA_W-1:0] out_q;
    if (CLK_INV) begin : g_inv
      assign oclk = ~clk_i;
    end else begin : g_true
      assign oclk = clk_i;
    end
    always_ff @(posedge oclk or negedge rst_ni) begin
      if (!rst_ni) out_q <= '0;
      else         out_q <= data_q;
    end
    assign data_o = out_q;
  end else begin : g_noreg
    assign data_o = data_q;
  end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
  import dpram_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 512,
  parameter bit OUT_REG_A = 1'b0,
  parameter bit OUT_REG_B = 1'b1,
  parameter bit CLK_INV_A = 1'b0,
  parameter bit CLK_INV_B = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_a_i,
  input  logic                     we_a_i,
  input  logic [$clog2(DEPTH)-1:0] addr_a_i,
  input  logic [DATA_W-1:0]        wdata_a_i,
  output logic [DATA_W-1:0]        rdata_a_o,
  input  logic                     en_b_i,
  input  logic                     we_b_i,
  input  logic [$clog2(DEPTH)-1:0] addr_b_i,
  input  logic [DATA_W-1:0]        wdata_b_i,
  output logic [DATA_W-1:0]        rdata_b_o,
  output logic                     match_no_o
);
  localparam int AW = $clog2(DEPTH);

  col_e              kind;
  logic              wr_a, wr_b;
  logic              upd_a, upd_b;
  logic              pend_a, pend_b;
  logic [DATA_W-1:0] upd_word_a, upd_word_b;
  logic [DATA_W-1:0] rdat_a, rdat_b;

  dpram_collide #(.DATA_W(DATA_W), .AW(AW)) u_col (
    .en_a_i      (en_a_i),
    .we_a_i      (we_a_i),
    .addr_a_i    (addr_a_i),
    .wdata_a_i   (wdata_a_i),
    .en_b_i      (en_b_i),
    .we_b_i      (we_b_i),
    .addr_b_i    (addr_b_i),
    .wdata_b_i   (wdata_b_i),
    .kind_o      (kind),
    .match_no_o  (match_no_o),
    .wr_a_o      (wr_a),
    .wr_b_o      (wr_b),
    .upd_a_o     (upd_a),
    .upd_word_a_o(upd_word_a),
    .upd_b_o     (upd_b),
    .upd_word_b_o(upd_word_b)
  );

  dpram_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i    (clk_i),
    .wr_a_i   (wr_a),
    .addr_a_i (addr_a_i),
    .wdata_a_i(wdata_a_i),
    .wr_b_i   (wr_b),
    .addr_b_i (addr_b_i),
    .wdata_b_i(wdata_b_i),
    .rdat_a_o (rdat_a),
    .rdat_b_o (rdat_b)
  );

  dpram_rdport #(.DATA_W(DATA_W), .OUT_REG(OUT_REG_A), .CLK_INV(CLK_INV_A)) u_rd_a (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (en_a_i && !we_a_i),
    .rd_word_i (rdat_a),
    .upd_i     (upd_a),
    .upd_word_i(upd_word_a),
    .pend_o    (pend_a),
    .data_o    (rdata_a_o)
  );

  dpram_rdport #(.DATA_W(DATA_W), .OUT_REG(OUT_REG_B), .CLK_INV(CLK_INV_B)) u_rd_b (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (en_b_i && !we_b_i),
    .rd_word_i (rdat_b),
    .upd_i     (upd_b),
    .upd_word_i(upd_word_b),
    .pend_o    (pend_b),
    .data_o    (rdata_b_o)
  );
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int DATA_W    = 8,
  parameter int AW        = 9,
  parameter bit OUT_REG_A = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_a_i,
  input logic              we_a_i,
  input logic [AW-1:0]     addr_a_i,
  input logic              en_b_i,
  input logic              we_b_i,
  input logic [AW-1:0]     addr_b_i,
  input logic [DATA_W-1:0] wdata_b_i,
  input logic [DATA_W-1:0] rdata_a_o,
  input logic              match_no_o,
  input logic              wr_b,
  input logic              pend_a,
  input logic [DATA_W-1:0] rdat_a
);
  p_match_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_a_i && en_b_i && addr_a_i == addr_b_i) |-> !match_no_o);

  p_match_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_a_i || !en_b_i) |-> match_no_o);

  p_ww_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_a_i && we_a_i && en_b_i && we_b_i && addr_a_i == addr_b_i) |-> !wr_b);

  if (!OUT_REG_A) begin : g_port_a
    p_rd_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_a_i && !we_a_i) |=> (rdata_a_o == $past(rdat_a)));

    p_refresh_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_a && !en_a_i) |=> (rdata_a_o == $past(wdata_b_i, 2)));

    p_hold_a_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_a_i && !pend_a) |=> $stable(rdata_a_o));
  end
endmodule

bind dpram_arb dpram_arb_chk #(.DATA_W(DATA_W), .AW(AW), .OUT_REG_A(OUT_REG_A)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_a_i    (en_a_i),
  .we_a_i    (we_a_i),
  .addr_a_i  (addr_a_i),
  .en_b_i    (en_b_i),
  .we_b_i    (we_b_i),
  .addr_b_i  (addr_b_i),
  .wdata_b_i (wdata_b_i),
  .rdata_a_o (rdata_a_o),
  .match_no_o(match_no_o),
  .wr_b      (wr_b),
  .pend_a    (pend_a),
  .rdat_a    (rdat_a)
);

// File: tb/sim_dpram_arb.sv
`timescale 1ns/1ps
module sim_dpram_arb;
  localparam int DW = 8;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_a = 0, we_a = 0, en_b = 0, we_b = 0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic [DW-1:0] wd_a = '0, wd_b = '0;
  logic [DW-1:0] rd_a, rd_b;
  logic          match_n;

  int errors = 0;
  int checks = 0;

  // bench model state
  logic [DW-1:0] mm [512];
  logic [DW-1:0] a_q = '0, b_q = '0, b_o = '0, pwa = '0, pwb = '0;
  logic          pa = 0, pb = 0;

  always #5 clk = ~clk;

  dpram_arb u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .en_a_i(en_a), .we_a_i(we_a), .addr_a_i(addr_a), .wdata_a_i(wd_a), .rdata_a_o(rd_a),
    .en_b_i(en_b), .we_b_i(we_b), .addr_b_i(addr_b), .wdata_b_i(wd_b), .rdata_b_o(rd_b),
    .match_no_o(match_n)
  );

  task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_match(input logic ea, input logic eb,
                                     input logic [AW-1:0] aa, input logic [AW-1:0] ab);
    return !(ea && eb && aa == ab);
  endfunction

  // model of one rising edge, built from the requirements
  task automatic model_edge();
    logic          col;
    logic [DW-1:0] na, nb;
    col = en_a && en_b && addr_a == addr_b;
    na = a_q;
    if (en_a && !we_a) na = mm[addr_a];
    else if (pa)       na = pwa;
    nb = b_q;
    if (en_b && !we_b) nb = mm[addr_b];
    else if (pb)       nb = pwb;
    b_o = b_q;
    if (col && !we_a && we_b) pwa = wd_b;
    if (col && we_a && !we_b) pwb = wd_a;
    pa = col && !we_a && we_b;
    pb = col && we_a && !we_b;
    if (en_a && we_a) mm[addr_a] = wd_a;
    if (en_b && we_b && !(col && we_a)) mm[addr_b] = wd_b;
    a_q = na;
    b_q = nb;
  endtask

  task automatic cyc(input string req,
                     input logic ea, input logic wa, input logic [AW-1:0] aa, input logic [DW-1:0] da,
                     input logic eb, input logic wb, input logic [AW-1:0] ab, input logic [DW-1:0] db);
    @(negedge clk);
    en_a = ea; we_a = wa; addr_a = aa; wd_a = da;
    en_b = eb; we_b = wb; addr_b = ab; wd_b = db;
    #1;
    chk("R3", "match_no", {7'd0, match_n}, {7'd0, exp_match(ea, eb, aa, ab)});
    @(posedge clk);
    model_edge();
    #1;
    chk(req, "rdata_a", rd_a, a_q);
    chk(req, "rdata_b", rd_b, b_o);
  endtask

  task automatic idle(input string req);
    cyc(req, 0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 512; i++) mm[i] = 'x;

    #22;
    // R10: reset values
    chk("R10", "rdata_a reset", rd_a, '0);
    chk("R10", "rdata_b reset", rd_b, '0);
    chk("R10", "match_no idle", {7'd0, match_n}, 8'd1);
    rst_n = 1'b1;

    // R1: fill window through both ports, top address through B
    for (int i = 0; i < 8; i += 2)
      cyc("R1", 1, 1, AW'(i), DW'(i * 17 + 3), 1, 1, AW'(i + 1), DW'(i * 29 + 5));
    cyc("R1", 0, 0, '0, '0, 1, 1, 9'd511, 8'hA5);
    cyc("R1", 1, 0, 9'd511, '0, 1, 0, 9'd0, '0);
    idle("R2");
    idle("R2");

    // R4: read/read same word
    cyc("R4", 1, 0, 9'd3, '0, 1, 0, 9'd3, '0);
    idle("R4");
    idle("R4");

    // R5: A writes, B reads same word; B idle after
    cyc("R5", 0, 0, '0, '0, 1, 0, 9'd5, '0);
    cyc("R5", 1, 1, 9'd5, 8'h5C, 1, 0, 9'd5, '0);
    idle("R5");
    idle("R5");
    idle("R5");

    // R6: B writes, A reads same word; A idle after
    cyc("R6", 1, 0, 9'd1, '0, 0, 0, '0, '0);
    cyc("R6", 1, 0, 9'd6, '0, 1, 1, 9'd6, 8'h6D);
    idle("R6");
    idle("R6");

    // R7: write/write, A wins
    cyc("R7", 1, 1, 9'd2, 8'h11, 1, 1, 9'd2, 8'h22);
    cyc("R7", 1, 0, 9'd2, '0, 1, 0, 9'd2, '0);
    idle("R7");
    idle("R7");

    // R8: write enable without port enable
    cyc("R8", 0, 1, 9'd4, 8'hFF, 0, 1, 9'd4, 8'hEE);
    cyc("R8", 1, 0, 9'd4, '0, 1, 0, 9'd4, '0);
    idle("R8");
    idle("R8");

    // R9: writes and idle cycles leave read data alone
    cyc("R9", 1, 0, 9'd0, '0, 1, 0, 9'd1, '0);
    idle("R9");
    cyc("R9", 1, 1, 9'd7, 8'h77, 1, 1, 9'd6, 8'h66);
    idle("R9");
    idle("R9");

    // R2: random mix over a small window to force collisions
    for (int n = 0; n < 400; n++) begin
      cyc("R2",
          1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), AW'($urandom_range(0, 7)), DW'($urandom),
          1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), AW'($urandom_range(0, 7)), DW'($urandom));
    end
    idle("R2");
    idle("R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule